// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a reversible binary counter, four bits wide by default, that has no direction bit. It has two count inputs instead. A rising edge on the increment line adds one to the count, provided the decrement line is being held high. A rising edge on the decrement line subtracts one, provided the increment line is being held high. A single system clock samples both lines through a two-flop synchronizer and detects their rising edges. Every state bit is written on the same clock edge, so the count moves from one value to the next without passing through any intermediate value.

An active-high clear input and an active-low preload input act as level overrides. The preload path copies a parallel data word into the count. Presetting the start value in this way shortens the count length, so the block can serve as a modulo-N divider. Two active-low outputs, borrow and carry, pulse during the low phase of the count input that is about to take the count past zero or past all-ones. Feeding borrow into the decrement input of the next stage, and carry into its increment input, builds a wider counter with no extra logic.

Top module: `twin_pulse_counter`

## Requirements
- R1: All count bits change on one clock edge. During a step from 7 to 8, `q` never shows any value other than 7 or 8.
- R2: A rising edge on `inc_in` while `dec_in` stays high raises `q` by one. `q` holds the new value by the third rising clock edge after the input edge.
- R3: A rising edge on `dec_in` while `inc_in` stays high lowers `q` by one, with the same latency as R2.
- R4: A rising edge on one count input is ignored while the other count input is low. Rising edges on both inputs in the same cycle are also ignored, and `q` stays unchanged.
- R5: While `preload_n` is low and `zap` is low, `q` takes the value of `din` on the next clock edge, and count edges have no effect.
- R6: While `zap` is high, `q` is 0 after the next clock edge, whatever `preload_n`, `din` and the count inputs are doing.
- R7: The count wraps from all-ones to 0 when counting up and from 0 to all-ones when counting down.
- R8: `borrow_n` is low only while `q` is 0 and the synchronized `dec_in` is low; otherwise it is high. It follows `dec_in` two clock edges late.
- R9: `carry_n` is low only while `q` is all-ones and the synchronized `inc_in` is low; otherwise it is high.
- R10: Two stages, with the low stage's `carry_n` wired to the high stage's `inc_in` and its `borrow_n` wired to the high stage's `dec_in`, count as a single 8-bit counter `{high q, low q}`. This holds in both directions, including the wrap below zero.
- R11: After reset, `q` is 0 and `borrow_n` and `carry_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| inc_in | input | 1 | Count-up line; a rising edge counts up |
| dec_in | input | 1 | Count-down line; a rising edge counts down |
| preload_n | input | 1 | Active-low parallel preset enable |
| zap | input | 1 | Active-high clear |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Current count |
| borrow_n | output | 1 | Active-low borrow, low while the count is 0 and the decrement line is low |
| carry_n | output | 1 | Active-low carry, low while the count is all-ones and the increment line is low |

## Verification
The bench targets the ordering rules around the two count lines.

- A rising edge that comes while the other line is low, or in the same cycle as a rising edge on the other line, must leave the count alone. A design that ignored the hold condition would step when it should not.
- When the lowered line is raised again, that edge is a real count. A design that filtered it out would lose a step.
- Preload is held across count pulses, and clear is held across preload. A design with the wrong priority would show the data word or a counted value.
- Both wraps are exercised. The borrow and carry pulses are checked for both their level and their two-cycle lag.
- A two-stage chain is counted up across a nibble boundary and then down through zero. A design that pulsed its cascade outputs on the wrong count, or on the wrong phase, would corrupt the upper nibble.

// File: rtl/twin_pulse_pkg.sv
package twin_pulse_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned LANE_INC = 0;
  localparam int unsigned LANE_DEC = 1;
  localparam int unsigned LANES    = 2;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] level_o,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] held_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], raw_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[LAST];
      end
    end

    assign level_o[g] = chain_q[LAST];
    assign rise_o[g]  = chain_q[LAST] & ~prev_q;
    assign held_o[g]  = chain_q[LAST] & prev_q;
  end
endmodule

// File: rtl/count_core.sv
module count_core
  import twin_pulse_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zap,
  input  logic             preload_n,
  input  logic [WIDTH-1:0] din,
  input  logic [LANES-1:0] rise,
  input  logic [LANES-1:0] held,
  output logic [WIDTH-1:0] q
);
  step_e            step;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    step = STEP_HOLD;
    if (rise[LANE_INC] && held[LANE_DEC])      step = STEP_UP;
    else if (rise[LANE_DEC] && held[LANE_INC]) step = STEP_DOWN;
  end

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (zap)             cnt_d = '0;
    else if (!preload_n) cnt_d = din;
    else begin
      unique case (step)
        STEP_UP:   cnt_d = cnt_q + 1'b1;
        STEP_DOWN: cnt_d = cnt_q - 1'b1;
        default:   cnt_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign q = cnt_q;
endmodule

// File: rtl/cascade_out.sv
module cascade_out #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             inc_lvl,
  input  logic             dec_lvl,
  output logic             borrow_n,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  always_comb begin
    borrow_n = ~((q == '0) & ~dec_lvl);
    carry_n  = ~((q == TOP) & ~inc_lvl);
  end
endmodule

// File: rtl/twin_pulse_counter.sv
module twin_pulse_counter
  import twin_pulse_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_in,
  input  logic             dec_in,
  input  logic             preload_n,
  input  logic             zap,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             borrow_n,
  output logic             carry_n
);
  logic             rst_meta, rst_sync_n;
  logic [LANES-1:0] raw, level, rise, held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    raw           = '0;
    raw[LANE_INC] = inc_in;
    raw[LANE_DEC] = dec_in;
  end

  edge_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .raw_i(raw),
    .level_o(level), .rise_o(rise), .held_o(held)
  );

  count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .zap(zap), .preload_n(preload_n),
    .din(din), .rise(rise), .held(held), .q(q)
  );

  cascade_out #(.WIDTH(WIDTH)) u_casc (
    .q(q), .inc_lvl(level[LANE_INC]), .dec_lvl(level[LANE_DEC]),
    .borrow_n(borrow_n), .carry_n(carry_n)
  );
endmodule

// File: rtl/twin_pulse_counter_chk.sv
module twin_pulse_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preload_n,
  input logic             zap,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             borrow_n,
  input logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zap |=> (q == '0));

  // R5
  preload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zap && !preload_n) |=> (q == $past(din)));

  // R1
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zap && preload_n) |=>
      (q == $past(q) || q == $past(q) + 1'b1 || q == $past(q) - 1'b1));

  // R8
  borrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == '0));

  // R9
  carry_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q == TOP));
endmodule

bind twin_pulse_counter twin_pulse_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .preload_n(preload_n), .zap(zap),
  .din(din), .q(q), .borrow_n(borrow_n), .carry_n(carry_n)
);

// File: tb/twin_pulse_counter_test.sv
module twin_pulse_counter_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inc_in = 1'b1, dec_in = 1'b1, preload_n = 1'b1, zap = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q, q_hi;
  logic         borrow_n, carry_n, borrow_hi, carry_hi;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  twin_pulse_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .inc_in(inc_in), .dec_in(dec_in),
    .preload_n(preload_n), .zap(zap), .din(din),
    .q(q), .borrow_n(borrow_n), .carry_n(carry_n)
  );

  twin_pulse_counter #(.WIDTH(W)) uut_hi (
    .clk(clk), .rst_n(rst_n), .inc_in(carry_n), .dec_in(borrow_n),
    .preload_n(1'b1), .zap(zap), .din(4'd0),
    .q(q_hi), .borrow_n(borrow_hi), .carry_n(carry_hi)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_inc(input int lo, input int hi);
    inc_in = 1'b0; cyc(lo); inc_in = 1'b1; cyc(hi);
  endtask

  task automatic pulse_dec(input int lo, input int hi);
    dec_in = 1'b0; cyc(lo); dec_in = 1'b1; cyc(hi);
  endtask

  task automatic set_count(input logic [W-1:0] v);
    din = v; preload_n = 1'b0; cyc(1); preload_n = 1'b1; cyc(1);
  endtask

  task automatic t_reset();
    check(q == 0, "R11 q", q, 0);
    check(borrow_n && carry_n, "R11 flags", {borrow_n, carry_n}, 3);
  endtask

  task automatic t_up_down();
    set_count(4'd3);
    pulse_inc(4, 4);
    check(q == 4, "R2 up", q, 4);
    pulse_inc(4, 4);
    check(q == 5, "R2 up again", q, 5);
    pulse_dec(4, 4);
    check(q == 4, "R3 down", q, 4);
  endtask

  task automatic t_atomic();
    bit ok = 1'b1;
    set_count(4'd7);
    inc_in = 1'b0; cyc(4); inc_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      if (q != 7 && q != 8) ok = 1'b0;
    end
    check(ok && q == 8, "R1 step 7->8", q, 8);
  endtask

  task automatic t_ignored();
    set_count(4'd6);
    dec_in = 1'b0; cyc(4);
    pulse_inc(4, 4);
    check(q == 6, "R4 up while down low", q, 6);
    dec_in = 1'b1; cyc(4);
    check(q == 5, "R3 down after restore", q, 5);
    inc_in = 1'b0; dec_in = 1'b0; cyc(4);
    inc_in = 1'b1; dec_in = 1'b1; cyc(4);
    check(q == 5, "R4 simultaneous rises", q, 5);
  endtask

  task automatic t_priority();
    din = 4'd9; preload_n = 1'b0;
    pulse_inc(4, 4);
    check(q == 9, "R5 preload over count", q, 9);
    din = 4'd12; cyc(1);
    check(q == 12, "R5 preload follows din", q, 12);
    zap = 1'b1; din = 4'd5; cyc(2);
    check(q == 0, "R6 clear over preload", q, 0);
    zap = 1'b0; preload_n = 1'b1; cyc(1);
  endtask

  task automatic t_wrap_borrow();
    zap = 1'b1; cyc(1); zap = 1'b0; cyc(1);
    dec_in = 1'b0; cyc(1);
    check(borrow_n == 1'b1, "R8 borrow lag", borrow_n, 1);
    cyc(2);
    check(borrow_n == 1'b0, "R8 borrow low", borrow_n, 0);
    dec_in = 1'b1; cyc(4);
    check(q == 15, "R7 wrap down", q, 15);
    check(borrow_n == 1'b1, "R8 borrow released", borrow_n, 1);
  endtask

  task automatic t_wrap_carry();
    set_count(4'd15);
    check(carry_n == 1'b1, "R9 carry idle", carry_n, 1);
    inc_in = 1'b0; cyc(3);
    check(carry_n == 1'b0, "R9 carry low", carry_n, 0);
    inc_in = 1'b1; cyc(4);
    check(q == 0, "R7 wrap up", q, 0);
    check(carry_n == 1'b1, "R9 carry released", carry_n, 1);
  endtask

  task automatic t_cascade();
    zap = 1'b1; cyc(2); zap = 1'b0; cyc(2);
    for (int i = 0; i < 20; i++) pulse_inc(4, 6);
    cyc(10);
    check({q_hi, q} == 8'd20, "R10 chain up", {q_hi, q}, 20);
    for (int i = 0; i < 25; i++) pulse_dec(4, 6);
    cyc(10);
    check({q_hi, q} == 8'd251, "R10 chain down", {q_hi, q}, 251);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(4);
    t_reset();
    t_up_down();
    t_atomic();
    t_ignored();
    t_priority();
    t_wrap_borrow();
    t_wrap_carry();
    t_cascade();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule